// File: doc/BRIEF.md
# UART Interrupt Combiner

This block gathers the interrupt causes of one serial channel into a single status byte and a single interrupt pin. Seven causes feed it: receive line errors, received data or a receive timeout, transmit space, modem line changes, a received Xoff character, a detected special character, and changes of the RTS or CTS flow lines. Each cause is latched or followed according to its own nature, gated by an enable byte, ranked by a fixed priority, and reported as one code in the status byte. Software reads that byte to learn the most urgent cause.

Each cause also has its own clearing rule. Some are cleared by reading the status byte, but only while they are the cause being reported. Others are cleared by reading the line status or the modem status, by writing the transmit holding register, by receiving a further character, or simply by their input condition going away. The pin is driven all the time when the select input is high. When the select input is low, the pin is driven only while the modem-control enable bit is set.

Causes are latched whatever the enable byte holds. With every enable cleared, software can poll the channel: the causes stay stored, while the pin and the status byte stay idle.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Status bit 0 is 1 when no enabled cause is pending and 0 when one is. With nothing pending, bits 5:1 read 0. Bits 7:6 both copy `fifo_on`, so idle reads 0x01, or 0xC1 with `fifo_on` high.
- R2: The reported cause follows a fixed priority, highest first, and each cause has its own code in bits 5:0. Line error is 0x06. Receive data is 0x04, or 0x0C when a receive timeout is present. Transmit is 0x02. Modem change is 0x00. Xoff and special character share 0x10, with Xoff ranked above special character. RTS/CTS change is 0x20.
- R3: A pulse on `lsr_err_evt` latches the line-error cause (enable bit 2). A pulse on `lsr_rd` clears it.
- R4: The receive cause (enable bit 0) follows the levels of `rx_ready` and `rx_timeout`. It is pending while either one is high and clears when both are low.
- R5: The transmit cause (enable bit 1) is latched by `tx_below_trig` and by `tx_empty_evt`. It is cleared by `thr_wr`, or by `isr_rd` while the transmit code is the one being reported. A status read while a higher cause is reported leaves it pending.
- R6: Any change on a bit of `modem_lvl` (bit 0 CTS, 1 DSR, 2 RI, 3 CD) sets the same bit of `msr_delta`. No change is flagged in the first cycle after reset. A set flag raises the modem cause only when enable bit 3 is set. A pulse on `msr_rd` clears all the flags.
- R7: `xoff_evt` latches the Xoff cause (enable bit 5). It is cleared by `isr_rd` while it is the cause being reported.
- R8: `spec_evt` latches the special-character cause (enable bit 5). It is cleared by `isr_rd` while it is the cause being reported, or by an `rx_char` pulse.
- R9: `rts_chg_evt` and `cts_chg_evt` latch the flow-change cause, gated by enable bit 6 and enable bit 7 respectively. A pulse on `msr_rd` clears both.
- R10: Latched causes are kept whatever the enable bits hold. With every enable bit clear, the status reads idle and the pin is inactive. Enabling a bit later reports a cause that was latched while it was disabled.
- R11: When a cause's event and its clear fall in the same cycle, the cause stays pending.
- R12: `int_oe` is 1 whenever `int_sel` is high, and equals `mcr_int_en` when `int_sel` is low. `int_o` sits at the active level (high by default) exactly when status bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier | input | 8 | Enable byte: bits 0 rx, 1 tx, 2 line, 3 modem, 5 Xoff/special, 6 RTS, 7 CTS |
| fifo_on | input | 1 | FIFO mode, copied into status bits 7:6 |
| int_sel | input | 1 | High selects an always-driven pin |
| mcr_int_en | input | 1 | Pin enable used when `int_sel` is low |
| lsr_err_evt | input | 1 | Receive line error event |
| rx_ready | input | 1 | Receive data at or above trigger (level) |
| rx_timeout | input | 1 | Receive timeout pending (level) |
| tx_below_trig | input | 1 | Transmit FIFO fell below its trigger |
| tx_empty_evt | input | 1 | Transmit FIFO became empty |
| modem_lvl | input | 4 | Modem input levels CTS, DSR, RI, CD |
| xoff_evt | input | 1 | Xoff character received |
| spec_evt | input | 1 | Special character detected |
| rx_char | input | 1 | A character was received |
| rts_chg_evt | input | 1 | RTS line changed |
| cts_chg_evt | input | 1 | CTS line changed |
| isr_rd | input | 1 | Status byte read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| thr_wr | input | 1 | Transmit holding write strobe |
| isr_val | output | 8 | Status byte |
| msr_delta | output | 4 | Modem change flags |
| int_o | output | 1 | Interrupt pin value |
| int_oe | output | 1 | Interrupt pin output enable |

## Verification
The function most likely to collide is the clear path of a cause and the arrival of a fresh event for that same cause. The bench provokes this by driving, in a single cycle, a status read together with a new Xoff event, a transmit-holding write together with a transmit-empty event, and a modem-status read together with a modem line toggle. After each of these cycles the cause must still be reported, or the delta bit must still be set. A later clear on its own must then bring the status back to idle, which shows that the earlier cause was not lost.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int N_SRC = 7;

   typedef enum logic [2:0] {
      S_LINE  = 3'd0,
      S_RX    = 3'd1,
      S_TX    = 3'd2,
      S_MODEM = 3'd3,
      S_XOFF  = 3'd4,
      S_SPEC  = 3'd5,
      S_FLOW  = 3'd6
   } src_e;

   localparam logic [7:0] C_NONE  = 8'h01;
   localparam logic [7:0] C_LINE  = 8'h06;
   localparam logic [7:0] C_RXD   = 8'h04;
   localparam logic [7:0] C_RXTO  = 8'h0C;
   localparam logic [7:0] C_TX    = 8'h02;
   localparam logic [7:0] C_MODEM = 8'h00;
   localparam logic [7:0] C_XSPEC = 8'h10;
   localparam logic [7:0] C_FLOW  = 8'h20;

   localparam int EN_RX    = 0;
   localparam int EN_TX    = 1;
   localparam int EN_LINE  = 2;
   localparam int EN_MODEM = 3;
   localparam int EN_XSPEC = 5;
   localparam int EN_RTS   = 6;
   localparam int EN_CTS   = 7;

endpackage

// File: rtl/irq_flag.sv
module irq_flag #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("irq_flag: W must be at least 1");
   end

   // set has priority over clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= set | (q & ~clr);
   end
endmodule

// File: rtl/irq_modem_delta.sv
module irq_modem_delta #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl,
   input  logic         clr,
   output logic [N-1:0] delta
);
   logic [N-1:0] prev;
   logic         primed;
   logic [N-1:0] chg;

   assign chg = primed ? (lvl ^ prev) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev   <= '0;
         primed <= 1'b0;
      end else begin
         prev   <= lvl;
         primed <= 1'b1;
      end
   end

   irq_flag #(.W(N)) u_dflag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (chg),
      .clr   ({N{clr}}),
      .q     (delta)
   );
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int N = 7
) (
   input  logic [N-1:0] pend,
   output logic [N-1:0] sel,
   output logic         any
);
   logic [N:0] seen;

   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_rank
      assign sel[i]    = pend[i] & ~seen[i];
      assign seen[i+1] = seen[i] | pend[i];
   end
   assign any = seen[N];
endmodule

// File: rtl/irq_pin.sv
module irq_pin #(
   parameter bit ACT_HIGH = 1'b1
) (
   input  logic pend,
   input  logic int_sel,
   input  logic mcr_int_en,
   output logic int_o,
   output logic int_oe
);
   if (ACT_HIGH) begin : g_high
      assign int_o = pend;
   end else begin : g_low
      assign int_o = ~pend;
   end

   assign int_oe = int_sel | mcr_int_en;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int MODEM_W         = 4,
   parameter bit INT_ACTIVE_HIGH = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [7:0]         ier,
   input  logic               fifo_on,
   input  logic               int_sel,
   input  logic               mcr_int_en,
   input  logic               lsr_err_evt,
   input  logic               rx_ready,
   input  logic               rx_timeout,
   input  logic               tx_below_trig,
   input  logic               tx_empty_evt,
   input  logic [MODEM_W-1:0] modem_lvl,
   input  logic               xoff_evt,
   input  logic               spec_evt,
   input  logic               rx_char,
   input  logic               rts_chg_evt,
   input  logic               cts_chg_evt,
   input  logic               isr_rd,
   input  logic               msr_rd,
   input  logic               lsr_rd,
   input  logic               thr_wr,
   output logic [7:0]         isr_val,
   output logic [MODEM_W-1:0] msr_delta,
   output logic               int_o,
   output logic               int_oe
);
   if (MODEM_W < 1 || MODEM_W > 8) begin : g_bad_modem
      $error("uart_irq_ctrl: MODEM_W must lie in 1..8");
   end

   localparam int NL = 6;  // latched single-bit causes: line, tx, xoff, spec, rts, cts
   localparam int L_LINE = 0, L_TX = 1, L_XOFF = 2, L_SPEC = 3, L_RTS = 4, L_CTS = 5;

   logic [NL-1:0]    l_set, l_clr, l_q;
   logic [N_SRC-1:0] pend, sel;
   logic             any;

   always_comb begin
      l_set          = '0;
      l_clr          = '0;
      l_set[L_LINE]  = lsr_err_evt;
      l_clr[L_LINE]  = lsr_rd;
      l_set[L_TX]    = tx_below_trig | tx_empty_evt;
      l_clr[L_TX]    = thr_wr | (isr_rd & sel[S_TX]);
      l_set[L_XOFF]  = xoff_evt;
      l_clr[L_XOFF]  = isr_rd & sel[S_XOFF];
      l_set[L_SPEC]  = spec_evt;
      l_clr[L_SPEC]  = rx_char | (isr_rd & sel[S_SPEC]);
      l_set[L_RTS]   = rts_chg_evt;
      l_clr[L_RTS]   = msr_rd;
      l_set[L_CTS]   = cts_chg_evt;
      l_clr[L_CTS]   = msr_rd;
   end

   irq_flag #(.W(NL)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (l_set),
      .clr   (l_clr),
      .q     (l_q)
   );

   irq_modem_delta #(.N(MODEM_W)) u_modem (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (modem_lvl),
      .clr   (msr_rd),
      .delta (msr_delta)
   );

   always_comb begin
      pend          = '0;
      pend[S_LINE]  = l_q[L_LINE] & ier[EN_LINE];
      pend[S_RX]    = (rx_ready | rx_timeout) & ier[EN_RX];
      pend[S_TX]    = l_q[L_TX] & ier[EN_TX];
      pend[S_MODEM] = (|msr_delta) & ier[EN_MODEM];
      pend[S_XOFF]  = l_q[L_XOFF] & ier[EN_XSPEC];
      pend[S_SPEC]  = l_q[L_SPEC] & ier[EN_XSPEC];
      pend[S_FLOW]  = (l_q[L_RTS] & ier[EN_RTS]) | (l_q[L_CTS] & ier[EN_CTS]);
   end

   irq_prio_enc #(.N(N_SRC)) u_enc (
      .pend (pend),
      .sel  (sel),
      .any  (any)
   );

   logic [7:0] code;
   always_comb begin
      code = C_NONE;
      if      (sel[S_LINE])  code = C_LINE;
      else if (sel[S_RX])    code = rx_timeout ? C_RXTO : C_RXD;
      else if (sel[S_TX])    code = C_TX;
      else if (sel[S_MODEM]) code = C_MODEM;
      else if (sel[S_XOFF])  code = C_XSPEC;
      else if (sel[S_SPEC])  code = C_XSPEC;
      else if (sel[S_FLOW])  code = C_FLOW;
   end

   assign isr_val = code | {fifo_on, fifo_on, 6'b0};

   irq_pin #(.ACT_HIGH(INT_ACTIVE_HIGH)) u_pin (
      .pend       (any),
      .int_sel    (int_sel),
      .mcr_int_en (mcr_int_en),
      .int_o      (int_o),
      .int_oe     (int_oe)
   );
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
   parameter int MODEM_W         = 4,
   parameter bit INT_ACTIVE_HIGH = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [7:0]         ier,
   input logic               int_sel,
   input logic               mcr_int_en,
   input logic               lsr_err_evt,
   input logic               msr_rd,
   input logic [MODEM_W-1:0] modem_lvl,
   input logic [7:0]         isr_val,
   input logic [MODEM_W-1:0] msr_delta,
   input logic               int_o,
   input logic               int_oe
);
   localparam logic ACT = INT_ACTIVE_HIGH;

   p_idle_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
      isr_val[0] |-> (isr_val[5:1] == 5'd0));

   p_line_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_err_evt && ier[2]) |=> (isr_val[5:0] == 6'h06));

   p_msr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_rd && $stable(modem_lvl)) |=> (msr_delta == '0));

   p_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ier == 8'h00) |-> isr_val[0]);

   p_pin_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
      int_oe |-> ((int_o == ACT) == !isr_val[0]));

   p_cont_drive_r12: assert property (@(posedge clk) disable iff (!rst_n)
      int_sel |-> int_oe);

   p_tristate_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_sel && !mcr_int_en) |-> !int_oe);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(
   .MODEM_W         (MODEM_W),
   .INT_ACTIVE_HIGH (INT_ACTIVE_HIGH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ier         (ier),
   .int_sel     (int_sel),
   .mcr_int_en  (mcr_int_en),
   .lsr_err_evt (lsr_err_evt),
   .msr_rd      (msr_rd),
   .modem_lvl   (modem_lvl),
   .isr_val     (isr_val),
   .msr_delta   (msr_delta),
   .int_o       (int_o),
   .int_oe      (int_oe)
);

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ier = 8'h00;
   logic       fifo_on = 1'b0, int_sel = 1'b1, mcr_int_en = 1'b0;
   logic       lsr_err_evt = 0, rx_ready = 0, rx_timeout = 0;
   logic       tx_below_trig = 0, tx_empty_evt = 0;
   logic [3:0] modem_lvl = 4'hF;
   logic       xoff_evt = 0, spec_evt = 0, rx_char = 0;
   logic       rts_chg_evt = 0, cts_chg_evt = 0;
   logic       isr_rd = 0, msr_rd = 0, lsr_rd = 0, thr_wr = 0;
   logic [7:0] isr_val;
   logic [3:0] msr_delta;
   logic       int_o, int_oe;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   uart_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .ier(ier), .fifo_on(fifo_on),
      .int_sel(int_sel), .mcr_int_en(mcr_int_en),
      .lsr_err_evt(lsr_err_evt), .rx_ready(rx_ready), .rx_timeout(rx_timeout),
      .tx_below_trig(tx_below_trig), .tx_empty_evt(tx_empty_evt),
      .modem_lvl(modem_lvl), .xoff_evt(xoff_evt), .spec_evt(spec_evt),
      .rx_char(rx_char), .rts_chg_evt(rts_chg_evt), .cts_chg_evt(cts_chg_evt),
      .isr_rd(isr_rd), .msr_rd(msr_rd), .lsr_rd(lsr_rd), .thr_wr(thr_wr),
      .isr_val(isr_val), .msr_delta(msr_delta), .int_o(int_o), .int_oe(int_oe)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // inputs change just after a falling edge, results are read at the next one
   task automatic t_reset();
      chk("R1 idle after reset", isr_val, 8'h01);
      chk("R12 pin inactive after reset", {7'd0, int_o}, 8'h00);
      chk("R6 no delta after reset", {4'd0, msr_delta}, 8'h00);
      fifo_on = 1; step();
      chk("R1 fifo bits", isr_val, 8'hC1);
      fifo_on = 0; step();
   endtask

   task automatic t_line();
      ier = 8'h04;
      lsr_err_evt = 1; step(); lsr_err_evt = 0;
      chk("R3 line latched", isr_val, 8'h06);
      chk("R12 pin active", {7'd0, int_o}, 8'h01);
      step();
      chk("R3 line held", isr_val, 8'h06);
      lsr_rd = 1; step(); lsr_rd = 0;
      chk("R3 line cleared", isr_val, 8'h01);
   endtask

   task automatic t_rx();
      ier = 8'h01;
      rx_ready = 1; step();
      chk("R4 rx data", isr_val, 8'h04);
      rx_timeout = 1; step();
      chk("R4 rx timeout code", isr_val, 8'h0C);
      rx_ready = 0; rx_timeout = 0; step();
      chk("R4 rx gone", isr_val, 8'h01);
   endtask

   task automatic t_tx();
      ier = 8'h02;
      tx_below_trig = 1; step(); tx_below_trig = 0;
      chk("R5 tx below trigger", isr_val, 8'h02);
      thr_wr = 1; step(); thr_wr = 0;
      chk("R5 tx cleared by write", isr_val, 8'h01);
      tx_empty_evt = 1; step(); tx_empty_evt = 0;
      chk("R5 tx empty", isr_val, 8'h02);
      isr_rd = 1; step(); isr_rd = 0;
      chk("R5 tx cleared by status read", isr_val, 8'h01);
      ier = 8'h06;
      tx_below_trig = 1; lsr_err_evt = 1; step(); tx_below_trig = 0; lsr_err_evt = 0;
      isr_rd = 1; step(); isr_rd = 0;
      lsr_rd = 1; step(); lsr_rd = 0;
      chk("R5 tx survives read of higher cause", isr_val, 8'h02);
      thr_wr = 1; step(); thr_wr = 0;
   endtask

   task automatic t_modem();
      ier = 8'h00;
      modem_lvl[0] = ~modem_lvl[0]; step();
      chk("R6 cts delta", {4'd0, msr_delta}, 8'h01);
      chk("R6 disabled modem idle", isr_val, 8'h01);
      ier = 8'h08; step();
      chk("R6 modem enabled", isr_val, 8'h00);
      msr_rd = 1; step(); msr_rd = 0;
      chk("R6 delta cleared", {4'd0, msr_delta}, 8'h00);
      chk("R6 modem cleared", isr_val, 8'h01);
      modem_lvl[3] = ~modem_lvl[3]; step();
      chk("R6 cd delta", {4'd0, msr_delta}, 8'h08);
      msr_rd = 1; step(); msr_rd = 0;
   endtask

   task automatic t_xspec();
      ier = 8'h20;
      xoff_evt = 1; step(); xoff_evt = 0;
      chk("R7 xoff", isr_val, 8'h10);
      spec_evt = 1; step(); spec_evt = 0;
      isr_rd = 1; step(); isr_rd = 0;
      chk("R7 xoff read leaves special", isr_val, 8'h10);
      rx_char = 1; step(); rx_char = 0;
      chk("R8 special cleared by next char", isr_val, 8'h01);
      spec_evt = 1; step(); spec_evt = 0;
      isr_rd = 1; step(); isr_rd = 0;
      chk("R8 special cleared by status read", isr_val, 8'h01);
   endtask

   task automatic t_flow();
      ier = 8'h40;
      cts_chg_evt = 1; step(); cts_chg_evt = 0;
      chk("R9 cts change gated by bit 7", isr_val, 8'h01);
      ier = 8'hC0; step();
      chk("R9 cts change", isr_val, 8'h20);
      msr_rd = 1; step(); msr_rd = 0;
      chk("R9 cleared by modem read", isr_val, 8'h01);
      ier = 8'h40;
      rts_chg_evt = 1; step(); rts_chg_evt = 0;
      chk("R9 rts change", isr_val, 8'h20);
      msr_rd = 1; step(); msr_rd = 0;
   endtask

   task automatic t_priority();
      ier = 8'hEF;
      lsr_err_evt = 1; rx_ready = 1; tx_below_trig = 1; xoff_evt = 1; rts_chg_evt = 1;
      modem_lvl[2] = ~modem_lvl[2];
      step();
      lsr_err_evt = 0; tx_below_trig = 0; xoff_evt = 0; rts_chg_evt = 0;
      chk("R2 line first", isr_val, 8'h06);
      lsr_rd = 1; step(); lsr_rd = 0;
      chk("R2 rx second", isr_val, 8'h04);
      rx_ready = 0; step();
      chk("R2 tx third", isr_val, 8'h02);
      thr_wr = 1; step(); thr_wr = 0;
      chk("R2 modem fourth", isr_val, 8'h00);
      msr_rd = 1; step(); msr_rd = 0;
      chk("R2 xoff after modem and flow clear", isr_val, 8'h10);
      isr_rd = 1; step(); isr_rd = 0;
      chk("R2 all clear", isr_val, 8'h01);
   endtask

   task automatic t_polled();
      ier = 8'h00;
      lsr_err_evt = 1; xoff_evt = 1; step(); lsr_err_evt = 0; xoff_evt = 0;
      chk("R10 masked status idle", isr_val, 8'h01);
      chk("R10 masked pin inactive", {7'd0, int_o}, 8'h00);
      ier = 8'h20; step();
      chk("R10 xoff retained", isr_val, 8'h10);
      isr_rd = 1; step(); isr_rd = 0;
      ier = 8'h04; step();
      chk("R10 line retained", isr_val, 8'h06);
      lsr_rd = 1; step(); lsr_rd = 0;
      ier = 8'h00;
   endtask

   task automatic t_collide();
      ier = 8'h20;
      xoff_evt = 1; step();
      isr_rd = 1; step(); isr_rd = 0; xoff_evt = 0;
      chk("R11 xoff set wins over read", isr_val, 8'h10);
      isr_rd = 1; step(); isr_rd = 0;
      chk("R11 xoff later cleared", isr_val, 8'h01);
      ier = 8'h02;
      tx_empty_evt = 1; step();
      thr_wr = 1; step(); thr_wr = 0; tx_empty_evt = 0;
      chk("R11 tx set wins over write", isr_val, 8'h02);
      thr_wr = 1; step(); thr_wr = 0;
      chk("R11 tx later cleared", isr_val, 8'h01);
      ier = 8'h08;
      msr_rd = 1; modem_lvl[1] = ~modem_lvl[1]; step(); msr_rd = 0;
      chk("R11 delta set wins over read", {4'd0, msr_delta}, 8'h02);
      msr_rd = 1; step(); msr_rd = 0;
      chk("R11 delta later cleared", {4'd0, msr_delta}, 8'h00);
   endtask

   task automatic t_pin();
      int_sel = 1; mcr_int_en = 0; step();
      chk("R12 continuous drive", {7'd0, int_oe}, 8'h01);
      int_sel = 0; step();
      chk("R12 three-state", {7'd0, int_oe}, 8'h00);
      mcr_int_en = 1; step();
      chk("R12 enabled by control bit", {7'd0, int_oe}, 8'h01);
      ier = 8'h04;
      lsr_err_evt = 1; step(); lsr_err_evt = 0;
      chk("R12 pin active when pending", {7'd0, int_o}, 8'h01);
      lsr_rd = 1; step(); lsr_rd = 0;
      chk("R12 pin inactive when clear", {7'd0, int_o}, 8'h00);
      int_sel = 1;
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1;
      repeat (3) step();
      t_reset();
      t_line();
      t_rx();
      t_tx();
      t_modem();
      t_xspec();
      t_flow();
      t_priority();
      t_polled();
      t_collide();
      t_pin();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule